// File: doc/BRIEF.md
# Light-Sensor I2C Register Target

This block is the serial register port of an ambient-light sensor. It listens on an oversampled I2C clock and data pair, recognises start and stop conditions, and answers only to the fixed 7-bit device address 0x44. A transfer that writes sets an internal 3-bit register pointer with its first data byte. The next byte, if sent, is stored in the addressed register. A transfer that reads, either fresh or after a repeated start, returns the byte at the current pointer.

The map holds eight bytes. Offsets 0 to 3 are writable and hold the command byte, the control byte, the upper alarm threshold and the lower alarm threshold. They keep their contents until overwritten. Offsets 4 to 7 are read-only views of the 16-bit conversion result (low byte, then high byte) and the 16-bit integration timer count (low byte, then high byte), taken from input pins. A write to the command byte that selects external timing also emits a one-cycle sync strobe. Downstream, the converter uses this strobe to bound its integration window.

The bus is modelled as open drain. The block never drives SDA high; it only asserts a pull-low enable. No data stream crosses the block edge, so all pins are plain levels with no valid/ready handshake. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `lux_i2c_target`

## Requirements
- R1: After reset the four writable registers read 0x00, the pull-low enable is inactive and the sync strobe is low.
- R2: An address byte whose upper seven bits equal 0x44 is acknowledged on the ninth clock. Any other address is not acknowledged, and every later byte is also not acknowledged until the next start or stop.
- R3: In a write transfer the address byte, the pointer byte and one data byte are each acknowledged. The data byte then appears on the output of the register at offset 0 to 3 that the pointer selects. Only pointer bits 2:0 are used.
- R4: A data byte written to offsets 4 to 7 is acknowledged but changes no register.
- R5: A second data byte in the same write transfer is not acknowledged and is not stored.
- R6: A read returns the pointed byte most significant bit first. Offsets 0 to 3 give the stored registers. Offset 4 gives sample bits 7:0, offset 5 sample bits 15:8, offset 6 timer bits 7:0 and offset 7 timer bits 15:8.
- R7: The pointer is kept across transfers, including across a repeated start. A read that sends no pointer byte returns the register last pointed to.
- R8: A write to offset 0 whose data has bit 5 (external timing select) set produces exactly one high cycle on the sync strobe. Any other write produces none.
- R9: Register contents do not change through reads, through address-mismatched transfers, or through any transfer that does not complete a data byte.
- R10: A stop condition at any point, including in the middle of a byte, ends the transfer and releases SDA. A later start begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| cmd_q | output | 8 | Command register (offset 0) |
| ctl_q | output | 8 | Control register (offset 1) |
| thr_hi_q | output | 8 | Upper alarm threshold (offset 2) |
| thr_lo_q | output | 8 | Lower alarm threshold (offset 3) |
| sample_i | input | 16 | Latest conversion result |
| timer_i | input | 16 | Clock count of the previous integration |
| ext_sync_o | output | 1 | One-cycle external timing sync strobe |

## Verification
The hardest states to reach from the pins are those where the target has stopped taking part in a transfer that is still running: after an address mismatch, after a surplus data byte, or after a stop cut a byte short. In each case it must stay silent and leave its registers untouched. The bench reaches them with a sweep over all 128 addresses, each followed by a further byte. It also sends a write with two data bytes and aborts a data byte after four bits. It then reads the register outputs and the ninth-clock acknowledge. Reads and writes sweep every offset and a spread of data values, so each map entry and each bit position is exercised.

// File: rtl/lux_i2c_pkg.sv
package lux_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 3;
  localparam int RW_REGS = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_IGNORE
  } eng_state_e;
endpackage

// File: rtl/lux_bus_sync.sv
module lux_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_pipe, sda_pipe;
  logic         scl_prev, sda_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe[0] <= scl_i;
          sda_pipe[0] <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
          sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[TOP];
      sda_prev <= sda_pipe[TOP];
    end
  end

  // Level changes of the synchronised lines; start/stop need SCL high on both samples
  assign sda_lvl   = sda_pipe[TOP];
  assign scl_rise  = scl_pipe[TOP] & ~scl_prev;
  assign scl_fall  = ~scl_pipe[TOP] & scl_prev;
  assign start_det = scl_pipe[TOP] & scl_prev & sda_prev & ~sda_pipe[TOP];
  assign stop_det  = scl_pipe[TOP] & scl_prev & ~sda_prev & sda_pipe[TOP];
endmodule

// File: rtl/lux_i2c_engine.sv
module lux_i2c_engine
  import lux_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  reg_ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_pull,
  output logic              quiet
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_full;
  logic              rd_mode;
  logic [BYTE_W-1:0] rx_shift;
  logic [BYTE_W-1:0] tx_shift;

  assign quiet = (state == ST_IDLE) || (state == ST_IGNORE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_full <= 1'b0;
      rd_mode   <= 1'b0;
      rx_shift  <= '0;
      tx_shift  <= '0;
      reg_ptr   <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      sda_pull  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_pull  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise && !byte_full) begin
              rx_shift <= {rx_shift[BYTE_W-2:0], sda_lvl};
              bit_cnt  <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bit_cnt   <= '0;
              case (state)
                ST_ADDR: begin
                  if (rx_shift[BYTE_W-1:1] == DEV_ADDR) begin
                    rd_mode  <= rx_shift[0];
                    sda_pull <= 1'b1;
                    state    <= ST_ADDR_ACK;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                ST_PTR: begin
                  reg_ptr  <= rx_shift[PTR_W-1:0];
                  sda_pull <= 1'b1;
                  state    <= ST_PTR_ACK;
                end
                default: begin
                  wr_en    <= 1'b1;
                  wr_data  <= rx_shift;
                  sda_pull <= 1'b1;
                  state    <= ST_WDATA_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                tx_shift <= rd_data;
                bit_cnt  <= '0;
                sda_pull <= ~rd_data[BYTE_W-1];
                state    <= ST_RDATA;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_IGNORE;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_pull <= 1'b0;
                state    <= ST_IGNORE;
              end else begin
                tx_shift <= {tx_shift[BYTE_W-2:0], 1'b0};
                sda_pull <= ~tx_shift[BYTE_W-2];
                bit_cnt  <= bit_cnt + 1'b1;
              end
            end
          end
          default: sda_pull <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lux_regfile.sv
module lux_regfile
  import lux_i2c_pkg::*;
#(
  parameter int EXT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  reg_ptr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2*BYTE_W-1:0] sample_i,
  input  logic [2*BYTE_W-1:0] timer_i,
  output logic [BYTE_W-1:0] rw_q [RW_REGS],
  output logic [BYTE_W-1:0] rd_data,
  output logic              ext_sync_o
);
  generate
    for (genvar g = 0; g < RW_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) rw_q[g] <= '0;
        else if (wr_en && reg_ptr == PTR_W'(g)) rw_q[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ext_sync_o <= 1'b0;
    else ext_sync_o <= wr_en && (reg_ptr == '0) && wr_data[EXT_BIT];
  end

  always_comb begin
    case (reg_ptr)
      3'd0:    rd_data = rw_q[0];
      3'd1:    rd_data = rw_q[1];
      3'd2:    rd_data = rw_q[2];
      3'd3:    rd_data = rw_q[3];
      3'd4:    rd_data = sample_i[BYTE_W-1:0];
      3'd5:    rd_data = sample_i[2*BYTE_W-1:BYTE_W];
      3'd6:    rd_data = timer_i[BYTE_W-1:0];
      default: rd_data = timer_i[2*BYTE_W-1:BYTE_W];
    endcase
  end
endmodule

// File: rtl/lux_i2c_target.sv
module lux_i2c_target
  import lux_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2,
  parameter int         EXT_BIT     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic [7:0]  cmd_q,
  output logic [7:0]  ctl_q,
  output logic [7:0]  thr_hi_q,
  output logic [7:0]  thr_lo_q,
  input  logic [15:0] sample_i,
  input  logic [15:0] timer_i,
  output logic        ext_sync_o
);
  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0]  reg_ptr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;
  logic              eng_quiet;
  logic [BYTE_W-1:0] rw_q [RW_REGS];

  lux_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  lux_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .reg_ptr(reg_ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_pull(sda_pull_o), .quiet(eng_quiet)
  );

  lux_regfile #(.EXT_BIT(EXT_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_ptr(reg_ptr),
    .wr_data(wr_data), .sample_i(sample_i), .timer_i(timer_i),
    .rw_q(rw_q), .rd_data(rd_data), .ext_sync_o(ext_sync_o)
  );

  assign cmd_q    = rw_q[0];
  assign ctl_q    = rw_q[1];
  assign thr_hi_q = rw_q[2];
  assign thr_lo_q = rw_q[3];
endmodule

// File: rtl/lux_i2c_checker.sv
module lux_i2c_checker #(
  parameter int EXT_BIT = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull_o,
  input logic       ext_sync_o,
  input logic [7:0] cmd_q,
  input logic [7:0] ctl_q,
  input logic [7:0] thr_hi_q,
  input logic [7:0] thr_lo_q,
  input logic       wr_en,
  input logic [2:0] reg_ptr,
  input logic [7:0] wr_data,
  input logic       stop_det,
  input logic       eng_quiet
);
  logic was_in_reset;

  always_ff @(posedge clk) begin
    was_in_reset <= !rst_n;
    if (was_in_reset && rst_n) begin
      a_r1_reset_state: assert ({cmd_q, ctl_q, thr_hi_q, thr_lo_q} == 32'h0
                                && !sda_pull_o && !ext_sync_o)
        else $error("R1 reset state wrong");
    end
  end

  a_r8_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync_o |=> !ext_sync_o);

  a_r8_sync_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync_o |-> $past(wr_en && reg_ptr == 3'd0 && wr_data[EXT_BIT]));

  a_r4_ro_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_ptr[2]) |=> $stable({cmd_q, ctl_q, thr_hi_q, thr_lo_q}));

  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({cmd_q, ctl_q, thr_hi_q, thr_lo_q}));

  a_r2_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    eng_quiet |-> !sda_pull_o);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);
endmodule

bind lux_i2c_target lux_i2c_checker #(.EXT_BIT(EXT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .ext_sync_o(ext_sync_o),
  .cmd_q(cmd_q), .ctl_q(ctl_q), .thr_hi_q(thr_hi_q), .thr_lo_q(thr_lo_q),
  .wr_en(wr_en), .reg_ptr(reg_ptr), .wr_data(wr_data),
  .stop_det(stop_det), .eng_quiet(eng_quiet)
);

// File: tb/lux_i2c_target_bench.sv
module lux_i2c_target_bench;
  localparam int Q = 6;
  localparam logic [7:0] WR_ADDR = 8'h88;
  localparam logic [7:0] RD_ADDR = 8'h89;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_pull_o;
  logic [7:0]  cmd_q, ctl_q, thr_hi_q, thr_lo_q;
  logic [15:0] sample_i = 16'h0000;
  logic [15:0] timer_i = 16'h0000;
  logic        ext_sync_o;
  logic        sda_bus;

  int tests = 0;
  int fails = 0;
  int sync_pulses = 0;
  int sync_high = 0;
  logic sync_prev = 1'b0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_pull_o;

  always #2.5 clk = ~clk;

  lux_i2c_target u_lux_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o), .cmd_q(cmd_q), .ctl_q(ctl_q),
    .thr_hi_q(thr_hi_q), .thr_lo_q(thr_lo_q), .sample_i(sample_i),
    .timer_i(timer_i), .ext_sync_o(ext_sync_o)
  );

  always @(posedge clk) begin
    if (ext_sync_o) sync_high <= sync_high + 1;
    if (ext_sync_o && !sync_prev) sync_pulses <= sync_pulses + 1;
    sync_prev <= ext_sync_o;
  end

  task automatic check(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(s);
    ack = !s;
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      get_bit(s);
      v[i] = s;
    end
    put_bit(1'b1);
  endtask

  task automatic write_reg(input logic [7:0] ptr, input logic [7:0] val, output int acks);
    logic a0, a1, a2;
    bus_start();
    put_byte(WR_ADDR, a0);
    put_byte(ptr, a1);
    put_byte(val, a2);
    bus_stop();
    acks = int'(a0) + int'(a1) + int'(a2);
  endtask

  task automatic read_reg(input logic [7:0] ptr, output logic [7:0] v, output int acks);
    logic a0, a1, a2;
    bus_start();
    put_byte(WR_ADDR, a0);
    put_byte(ptr, a1);
    bus_start();
    put_byte(RD_ADDR, a2);
    get_byte(v);
    bus_stop();
    acks = int'(a0) + int'(a1) + int'(a2);
  endtask

  function automatic logic [7:0] pattern(int r);
    return 8'(8'h5A ^ (r * 8'h13));
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic a, b;
    int acks;
    int exp_sync;
    logic [7:0] exp_reg [4];

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 cmd_q", cmd_q, 0);
    check("R1 ctl_q", ctl_q, 0);
    check("R1 thr_hi_q", thr_hi_q, 0);
    check("R1 thr_lo_q", thr_lo_q, 0);
    check("R1 sda_pull_o", sda_pull_o, 0);
    check("R1 ext_sync_o", ext_sync_o, 0);

    // R2 every address, followed by a further byte
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      put_byte({7'(ad), 1'b0}, a);
      put_byte(8'h00, b);
      bus_stop();
      check($sformatf("R2 addr %0h ack", ad), a, (ad == 'h44) ? 1 : 0);
      check($sformatf("R2 addr %0h next byte ack", ad), b, (ad == 'h44) ? 1 : 0);
    end
    check("R9 regs after address sweep", {cmd_q, ctl_q, thr_hi_q, thr_lo_q}, 0);

    // R3 R4 write every offset, R8 counted throughout
    exp_sync = 0;
    for (int r = 0; r < 4; r++) exp_reg[r] = 8'h00;
    for (int r = 0; r < 8; r++) begin
      write_reg(8'(r) | 8'hF8 & 8'(r << 3), pattern(r), acks);
      check($sformatf("R3 R4 write offset %0d acks", r), acks, 3);
      if (r < 4) exp_reg[r] = pattern(r);
      if (r == 0 && pattern(r)[5]) exp_sync++;
    end
    check("R3 cmd_q", cmd_q, exp_reg[0]);
    check("R3 ctl_q", ctl_q, exp_reg[1]);
    check("R3 thr_hi_q", thr_hi_q, exp_reg[2]);
    check("R3 R4 thr_lo_q", thr_lo_q, exp_reg[3]);

    // R6 read every offset under several input patterns
    for (int k = 0; k < 4; k++) begin
      sample_i = 16'((k + 1) * 16'h1234);
      timer_i = ~16'((k + 3) * 16'h0F1D);
      for (int r = 0; r < 8; r++) begin
        logic [7:0] e;
        read_reg(8'(r), rv, acks);
        case (r)
          0, 1, 2, 3: e = exp_reg[r];
          4: e = sample_i[7:0];
          5: e = sample_i[15:8];
          6: e = timer_i[7:0];
          default: e = timer_i[15:8];
        endcase
        check($sformatf("R6 read acks offset %0d", r), acks, 3);
        check($sformatf("R6 R4 read offset %0d pattern %0d", r, k), rv, e);
      end
    end

    // R3 R6 data value sweep on the control register
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 17) ^ 8'(i << 1);
      write_reg(8'h01, v, acks);
      check($sformatf("R3 ctl_q value %0h", v), ctl_q, v);
      read_reg(8'h01, rv, acks);
      check($sformatf("R6 ctl readback %0h", v), rv, v);
    end
    exp_reg[1] = ctl_q;

    // R5 surplus data byte
    bus_start();
    put_byte(WR_ADDR, a);
    put_byte(8'h02, a);
    put_byte(8'hC3, a);
    put_byte(8'h3C, b);
    bus_stop();
    check("R5 first data ack", a, 1);
    check("R5 second data nack", b, 0);
    check("R5 thr_hi_q keeps first", thr_hi_q, 8'hC3);
    exp_reg[2] = 8'hC3;

    // R7 pointer kept: read without pointer after a write
    write_reg(8'h03, 8'h96, acks);
    bus_start();
    put_byte(RD_ADDR, a);
    get_byte(rv);
    bus_stop();
    check("R7 read ack", a, 1);
    check("R7 read without pointer", rv, 8'h96);
    exp_reg[3] = 8'h96;
    // pointer-only transfer then separate read
    bus_start();
    put_byte(WR_ADDR, a);
    put_byte(8'h01, a);
    bus_stop();
    bus_start();
    put_byte(RD_ADDR, a);
    get_byte(rv);
    bus_stop();
    check("R7 pointer-only then read", rv, exp_reg[1]);
    check("R9 ctl_q after pointer-only", ctl_q, exp_reg[1]);

    // R8 sync strobe
    repeat (4) @(negedge clk);
    check("R8 sync count after sweep", sync_pulses, exp_sync);
    write_reg(8'h00, 8'h20, acks); exp_sync++;
    check("R8 sync on bit5", sync_pulses, exp_sync);
    write_reg(8'h00, 8'hDF, acks);
    check("R8 no sync without bit5", sync_pulses, exp_sync);
    write_reg(8'h01, 8'hFF, acks);
    check("R8 no sync for control write", sync_pulses, exp_sync);
    write_reg(8'h04, 8'hFF, acks);
    check("R8 no sync for read-only write", sync_pulses, exp_sync);
    write_reg(8'h00, 8'hFF, acks); exp_sync++;
    check("R8 sync on 0xFF", sync_pulses, exp_sync);
    check("R8 strobe one cycle wide", sync_high, sync_pulses);
    check("R8 cmd_q", cmd_q, 8'hFF);
    exp_reg[0] = 8'hFF;
    exp_reg[1] = 8'hFF;

    // R2 R9 mismatch followed by bytes that would be a write
    bus_start();
    put_byte(8'h8A, a);
    put_byte(8'h01, b);
    check("R2 mismatch nack", a, 0);
    check("R2 ignored pointer nack", b, 0);
    put_byte(8'h00, b);
    bus_stop();
    check("R2 ignored data nack", b, 0);
    check("R9 regs after mismatch",
          {cmd_q, ctl_q, thr_hi_q, thr_lo_q},
          {exp_reg[0], exp_reg[1], exp_reg[2], exp_reg[3]});

    // R10 stop in the middle of a data byte
    bus_start();
    put_byte(WR_ADDR, a);
    put_byte(8'h02, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    repeat (4) @(negedge clk);
    check("R10 released after stop", sda_pull_o, 0);
    check("R10 R9 thr_hi_q untouched", thr_hi_q, exp_reg[2]);
    write_reg(8'h02, 8'h7E, acks);
    check("R10 new transfer acks", acks, 3);
    check("R10 new transfer writes", thr_hi_q, 8'h7E);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule